// File: doc/BRIEF.md
# GPIO grouped interrupt controller

This block watches up to four 32-bit GPIO input ports and turns their activity into one interrupt line. It does not give each pin its own interrupt. Instead it offers eight shared interrupt groups. Group g can only be fed by bit g of some 8-bit byte lane. A 4-bit selector per group picks the port and the lane, and a 3-bit trigger code per group picks the condition that makes the group pending. The trigger can be a level, an edge, always, or never.

Software programs the block through a plain single-cycle register bus with no handshake. A write takes effect at the clock edge where `bus_wr` is high. A read returns combinationally the word addressed by `bus_addr`. There is no data stream at the edge of the block, so no valid/ready back-pressure applies.

Each pin passes through a two-flop synchronizer. A third flop holds the previous synchronized value, and edges are found by comparing against it. An edge latches a sticky pending bit, which software clears with a write-one acknowledge. Level and always-on conditions are reported directly and cannot be acknowledged away. Pending groups are ANDed with a mask, and the OR of the result drives `irq`.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset, the trigger word, the selector word and the mask all read 0, the masked status reads 0 and `irq` is 0.
- R2: Register words are addressed by word index:
  - index 0 holds the trigger codes, 3 bits per group at [3g+2:3g], and bits 31:24 read 0.
  - index 1 holds the selectors, 4 bits per group at [4g+3:4g].
  - index 2 holds the mask in bits 7:0.
  - index 3 is the write-only acknowledge and reads 0.
  - index 4 is the masked status in bits 7:0.
- R3: A selector value s = 4*port + lane makes group g observe input bit port*32 + lane*8 + g. No other input bit affects that group.
- R4: Trigger code 1 makes the group pending while its synchronized pin is 1. Code 2 makes it pending while the pin is 0. An acknowledge has no effect in these modes.
- R5: Trigger code 3 makes the group pending at all times. Codes 0 and 4 make it never pending.
- R6: Codes 5 (rising), 6 (falling) and 7 (either edge) latch a sticky pending bit when the selected pin makes the matching transition. The bit stays set after the pin returns. A transition in the other direction does not set it.
- R7: Writing the acknowledge word clears the edge pending bit of every group whose data bit is 1. Groups whose data bit is 0 are unchanged.
- R8: The masked status equals the pending bits ANDed with the mask. `irq` is 1 exactly when the masked status is nonzero. A group that becomes pending while masked appears as soon as its mask bit is set.
- R9: A pin change driven before clock edge k shows up in level modes after edge k+1, and in edge modes after edge k+2.
- R10: Changing a group to a non-edge code discards its latched edge pending bit. Returning to an edge code does not bring the bit back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | NUM_PORTS*PORT_W | Asynchronous GPIO input levels, port p at bits [p*PORT_W +: PORT_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
Some state cannot be read directly from the ports: an edge latched while the group is masked, and an edge bit that should be gone after a trip through a non-edge code. Both hide behind the mask and the code. The stimulus reaches them by counting synchronizer cycles exactly. The bench drives the selected pin, waits the stated latency, and then changes the mask or the code. The status read after that shows whether the hidden bit survived or vanished as required. Acknowledges are also issued while a level is still asserted, and with the wrong bits set, to show they leave the pending state alone.

// File: rtl/gpio_grp_pkg.sv
`timescale 1ns/1ps
package gpio_grp_pkg;
  localparam int NUM_GROUPS = 8;
  localparam int TRIG_W     = 3;
  localparam int SELF_W     = 4;
  localparam int CFG_BITS   = NUM_GROUPS * TRIG_W;
  localparam int SEL_BITS   = NUM_GROUPS * SELF_W;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_ON   = 3'd3,
    TRIG_RSV  = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_BOTH = 3'd7
  } trig_e;

  localparam int A_CFG  = 0;
  localparam int A_SEL  = 1;
  localparam int A_MASK = 2;
  localparam int A_ACK  = 3;
  localparam int A_STAT = 4;
endpackage

// File: rtl/gpio_grp_regs.sv
`timescale 1ns/1ps
module gpio_grp_regs
  import gpio_grp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_GROUPS-1:0] status,
  output logic [CFG_BITS-1:0]   cfg_q,
  output logic [SEL_BITS-1:0]   sel_q,
  output logic [NUM_GROUPS-1:0] mask_q,
  output logic [NUM_GROUPS-1:0] ack_pulse
);
  logic hit_cfg, hit_sel, hit_mask, hit_ack, hit_stat;

  assign hit_cfg  = (bus_addr == ADDR_W'(A_CFG));
  assign hit_sel  = (bus_addr == ADDR_W'(A_SEL));
  assign hit_mask = (bus_addr == ADDR_W'(A_MASK));
  assign hit_ack  = (bus_addr == ADDR_W'(A_ACK));
  assign hit_stat = (bus_addr == ADDR_W'(A_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (hit_cfg)  cfg_q  <= bus_wdata[CFG_BITS-1:0];
      if (hit_sel)  sel_q  <= bus_wdata[SEL_BITS-1:0];
      if (hit_mask) mask_q <= bus_wdata[NUM_GROUPS-1:0];
    end
  end

  assign ack_pulse = (bus_wr && hit_ack) ? bus_wdata[NUM_GROUPS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)  bus_rdata = 32'(cfg_q);
    if (hit_sel)  bus_rdata = 32'(sel_q);
    if (hit_mask) bus_rdata = 32'(mask_q);
    if (hit_stat) bus_rdata = 32'(status);
  end
endmodule

// File: rtl/gpio_grp_lane.sv
`timescale 1ns/1ps
module gpio_grp_lane
  import gpio_grp_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   cand,
  input  logic [SELF_W-1:0] sel,
  input  logic [TRIG_W-1:0] mode,
  input  logic              ack,
  output logic              pend,
  output logic              edge_pend,
  output logic              edge_evt
);
  logic src, s_meta, s_sync, s_prev;
  logic rise, fall, edge_mode;
  trig_e trig;

  always_comb begin
    src = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (sel == SELF_W'(k)) src = cand[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= src;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign trig = trig_e'(mode);
  assign rise = s_sync & ~s_prev;
  assign fall = ~s_sync & s_prev;

  always_comb begin
    edge_mode = 1'b0;
    edge_evt  = 1'b0;
    case (trig)
      TRIG_RISE: begin edge_mode = 1'b1; edge_evt = rise;        end
      TRIG_FALL: begin edge_mode = 1'b1; edge_evt = fall;        end
      TRIG_BOTH: begin edge_mode = 1'b1; edge_evt = rise | fall; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          edge_pend <= 1'b0;
    else if (!edge_mode) edge_pend <= 1'b0;
    else                 edge_pend <= (edge_pend & ~ack) | edge_evt;
  end

  always_comb begin
    case (trig)
      TRIG_HIGH: pend = s_sync;
      TRIG_LOW:  pend = ~s_sync;
      TRIG_ON:   pend = 1'b1;
      TRIG_RISE, TRIG_FALL, TRIG_BOTH: pend = edge_pend;
      default:   pend = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_group_irq.sv
`timescale 1ns/1ps
module gpio_group_irq
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq
);
  localparam int LANES     = PORT_W / 8;
  localparam int SLOTS_PER = 4;
  localparam int NSRC      = NUM_PORTS * SLOTS_PER;

  logic [CFG_BITS-1:0]   cfg_q;
  logic [SEL_BITS-1:0]   sel_q;
  logic [NUM_GROUPS-1:0] mask_q, ack_pulse;
  logic [NUM_GROUPS-1:0] grp_pend, edge_pend, edge_evt, stat;

  gpio_grp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(stat),
    .cfg_q(cfg_q), .sel_q(sel_q), .mask_q(mask_q), .ack_pulse(ack_pulse)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [NSRC-1:0] cand;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar l = 0; l < SLOTS_PER; l++) begin : g_lane
        if (l < LANES) begin : g_live
          assign cand[p*SLOTS_PER + l] = gpio_in[p*PORT_W + l*8 + g];
        end else begin : g_tie
          assign cand[p*SLOTS_PER + l] = 1'b0;
        end
      end
    end

    gpio_grp_lane #(.NSRC(NSRC)) u_lane (
      .clk(clk), .rst_n(rst_n), .cand(cand),
      .sel(sel_q[SELF_W*g +: SELF_W]), .mode(cfg_q[TRIG_W*g +: TRIG_W]),
      .ack(ack_pulse[g]), .pend(grp_pend[g]),
      .edge_pend(edge_pend[g]), .edge_evt(edge_evt[g])
    );
  end

  assign stat = grp_pend & mask_q;
  assign irq  = |stat;
endmodule

// File: rtl/gpio_group_irq_chk.sv
`timescale 1ns/1ps
module gpio_group_irq_chk
  import gpio_grp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic                  irq,
  input logic [CFG_BITS-1:0]   cfg_q,
  input logic [NUM_GROUPS-1:0] mask_q,
  input logic [NUM_GROUPS-1:0] grp_pend,
  input logic [NUM_GROUPS-1:0] edge_pend,
  input logic [NUM_GROUPS-1:0] edge_evt
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq && mask_q == '0));

  p_irq_matches_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_STAT)) |-> (irq == (bus_rdata[7:0] != 8'd0)));

  p_status_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_STAT)) |-> ((bus_rdata[7:0] & ~mask_q) == 8'd0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_on_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3*g +: 3] == 3'd3) |-> grp_pend[g]);

    p_off_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3*g +: 3] == 3'd0 || cfg_q[3*g +: 3] == 3'd4) |-> !grp_pend[g]);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(A_ACK) && bus_wdata[g] && !edge_evt[g])
      |=> !edge_pend[g]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_pend[g] && !bus_wr) |=> edge_pend[g]);

    p_leave_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[3*g +: 3] < 3'd5) |=> !edge_pend[g]);
  end
endmodule

bind gpio_group_irq gpio_group_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .cfg_q(cfg_q), .mask_q(mask_q), .grp_pend(grp_pend),
  .edge_pend(edge_pend), .edge_evt(edge_evt)
);

// File: tb/tb_gpio_group_irq.sv
`timescale 1ns/1ps
module tb_gpio_group_irq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] gpio_in = '0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_group_irq dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {group[2:0], code[2:0], selector[3:0], pin, expected}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 3'd1, 4'd0,  1'b1, 1'b1},  // R4 high level asserted
    {3'd0, 3'd1, 4'd0,  1'b0, 1'b0},  // R4 high level idle
    {3'd3, 3'd2, 4'd5,  1'b0, 1'b1},  // R4 low level asserted
    {3'd3, 3'd2, 4'd5,  1'b1, 1'b0},  // R4 low level idle
    {3'd7, 3'd3, 4'd15, 1'b0, 1'b1},  // R5 always on
    {3'd5, 3'd0, 4'd2,  1'b1, 1'b0},  // R5 off
    {3'd2, 3'd4, 4'd9,  1'b1, 1'b0},  // R5 reserved acts as off
    {3'd6, 3'd1, 4'd14, 1'b1, 1'b1}   // R3 high port/lane
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int pin_idx(input int grp, input int sel);
    return (sel >> 2) * 32 + (sel & 3) * 8 + grp;
  endfunction

  task automatic stat_is(input string req, input logic [7:0] exp);
    logic [31:0] d;
    rd(3'd4, d);
    chk(req, d, {24'd0, exp});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp != 8'd0});
  endtask

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(3'd0, d); chk("R1 trigger word", d, 32'd0);
    rd(3'd1, d); chk("R1 selector word", d, 32'd0);
    rd(3'd2, d); chk("R1 mask", d, 32'd0);
    stat_is("R1 status", 8'h00);

    // R2 register readback
    wr(3'd0, 32'hFFFA_C688); rd(3'd0, d); chk("R2 trigger readback", d, 32'h00FA_C688);
    wr(3'd1, 32'h9ABC_DEF1); rd(3'd1, d); chk("R2 selector readback", d, 32'h9ABC_DEF1);
    wr(3'd2, 32'hFFFF_FF5A); rd(3'd2, d); chk("R2 mask readback", d, 32'h0000_005A);
    rd(3'd3, d); chk("R2 ack reads zero", d, 32'd0);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      int g, m, s;
      g = int'(VEC[i][11:9]); m = int'(VEC[i][8:6]); s = int'(VEC[i][5:2]);
      gpio_in = '0;
      wr(3'd0, 32'(m) << (3*g));
      wr(3'd1, 32'(s) << (4*g));
      wr(3'd2, 32'hFF);
      tick(3);
      gpio_in[pin_idx(g, s)] = VEC[i][1];
      tick(3);
      stat_is($sformatf("R4/R5/R3 vector %0d", i), VEC[i][0] ? 8'(1 << g) : 8'h00);
    end

    // R3 only the selected lane bit matters: group 1, selector 0 -> bit 1
    gpio_in = '0;
    wr(3'd0, 32'd1 << 3); wr(3'd1, 0); wr(3'd2, 32'h02);
    gpio_in[9] = 1'b1; gpio_in[0] = 1'b1; gpio_in[2] = 1'b1; gpio_in[33] = 1'b1;
    tick(3);
    stat_is("R3 other bits ignored", 8'h00);
    gpio_in[1] = 1'b1;
    tick(3);
    stat_is("R3 selected bit", 8'h02);

    // R9 level latency, R4 ack ignored in level mode (group 0 high)
    gpio_in = '0;
    wr(3'd0, 32'd1); wr(3'd1, 0); wr(3'd2, 32'h01);
    tick(3);
    gpio_in[0] = 1'b1;
    tick();
    stat_is("R9 level not yet", 8'h00);
    tick();
    stat_is("R9 level after two edges", 8'h01);
    wr(3'd3, 32'h01);
    tick();
    stat_is("R4 ack ignored while level", 8'h01);

    // R6 / R9 rising edge on group 4
    gpio_in = '0;
    wr(3'd0, 32'd5 << 12); wr(3'd1, 0); wr(3'd2, 32'h10);
    tick(3);
    gpio_in[4] = 1'b1;
    tick(2);
    stat_is("R9 edge not yet", 8'h00);
    tick();
    stat_is("R6 rising latched", 8'h10);
    gpio_in[4] = 1'b0;
    tick(3);
    stat_is("R6 sticky after release", 8'h10);
    wr(3'd3, 32'hEF);
    stat_is("R7 zero bit no effect", 8'h10);
    wr(3'd3, 32'h10);
    stat_is("R7 ack clears", 8'h00);
    gpio_in[4] = 1'b1;
    tick(3);
    wr(3'd3, 32'h10);
    tick(3);
    stat_is("R7 held level no new edge", 8'h00);
    gpio_in[4] = 1'b0;
    tick(3);
    stat_is("R6 falling ignored in rise mode", 8'h00);

    // R6 falling edge mode
    wr(3'd0, 32'd6 << 12);
    gpio_in[4] = 1'b1;
    tick(3);
    stat_is("R6 rising ignored in fall mode", 8'h00);
    gpio_in[4] = 1'b0;
    tick(3);
    stat_is("R6 falling latched", 8'h10);

    // R10 leaving edge mode discards pending
    wr(3'd0, 32'd0);
    stat_is("R10 off hides", 8'h00);
    wr(3'd0, 32'd7 << 12);
    tick();
    stat_is("R10 not restored", 8'h00);

    // R6 either edge
    gpio_in[4] = 1'b1;
    tick(3);
    stat_is("R6 either edge rise", 8'h10);
    wr(3'd3, 32'h10);
    gpio_in[4] = 1'b0;
    tick(3);
    stat_is("R6 either edge fall", 8'h10);

    // R8 pending survives while masked
    wr(3'd3, 32'h10);
    wr(3'd0, 32'd5 << 12); wr(3'd2, 32'h00);
    gpio_in[4] = 1'b1;
    tick(3);
    stat_is("R8 masked hides", 8'h00);
    wr(3'd2, 32'h10);
    stat_is("R8 unmask reveals", 8'h10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule